// File: doc/BRIEF.md
# H-bridge control and fault logic

This block is the digital controller for a full motor bridge built from two half-bridges, A and B. Each half-bridge has a high-side switch and a low-side gate drive. Two direction inputs and two enable inputs select the drive, brake and single-half-bridge modes from a fixed decode. A PWM input chops only the low-side gates. A programmable dead time holds back every low-side turn-on. Supply faults, protection flags and a load-continuity test mode override the decode.

Each shared enable/diagnostic line is split into two ports: an external enable level and an active-high pull-down request from the block. The enable the block acts on is the external level ANDed with the inverse of its own pull-down. A protection flag latches its half-bridge off and asserts the pull-down. The latch stays set until that side's direction input makes a new low-to-high transition while the flag is clear. All analog sensing is outside the block; flags arrive as synchronous inputs. Vectors are indexed with bit 0 = half-bridge A and bit 1 = half-bridge B, and an output bit of 1 means that switch is on.

Top module: `hb_ctrl`

## Requirements
- R1: With both enables high and no fault, each enabled side whose direction bit is 1 turns its high-side on, and each whose direction bit is 0 turns its low-side gate on. Direction 11 gives brake to supply, 00 gives brake to ground, and 01 or 10 drives one way or the other. Switch outputs are registered and follow the inputs one clock edge later (low sides are further delayed by R5).
- R2: With both external enables low outside test mode, all four switch outputs are off whatever the direction inputs are.
- R3: With exactly one enable low, that half-bridge is fully off and the other follows its own direction bit as in R1.
- R4: A low pwm forces both low-side outputs off one edge later. Raising pwm again restores them one edge later without a new dead time. pwm never changes the high-side outputs.
- R5: A low-side output turns on only once its command has been stable for dead_cycles further edges. A command first present before edge k appears at edge k+dead_cycles+1. Any change of the command restarts the count.
- R6: The high-side and low-side outputs of the same half-bridge are never on together.
- R7: A high ovt or sat bit on a side latches a fault at the next edge. That side's diag_pd goes high from that edge and its switches are off one edge later. While any fault is latched, both low-side outputs stay off and the healthy side's high-side still follows its direction bit.
- R8: A latched fault clears only at an edge where that side's direction bit is 1, was 0 at the previous edge, and its flags are low. A direction held high, or a rise while a flag is still high, leaves it latched.
- R9: In test mode both low-side outputs are off, each high-side follows its direction bit regardless of the enables, and a high load_open bit drives that side's diag_pd high in the same cycle.
- R10: While uv or ov is high, all four switch outputs are off one edge later, and they return one edge after the condition ends.
- R11: A low rst_n at a clock edge clears every fault latch, every dead-time counter and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dead_cycles | input | DT_W | Low-side turn-on dead time in clock cycles |
| dir | input | 2 | Direction bits, bit 0 side A, bit 1 side B |
| en_ext | input | 2 | External level of each enable/diagnostic line |
| pwm | input | 1 | Low-side chopping input, high = allow |
| test_mode | input | 1 | Load-continuity test mode |
| ovt | input | 2 | High-side overtemperature flags |
| sat | input | 2 | External low-side saturation flags |
| load_open | input | 2 | Open-load flags, used in test mode |
| uv | input | 1 | Supply undervoltage |
| ov | input | 1 | Supply overvoltage |
| hs_on | output | 2 | High-side switch drives |
| ls_on | output | 2 | Low-side gate drives |
| diag_pd | output | 2 | Pull-down request on each enable/diagnostic line |

## Verification
The bench probes the dead time exactly at its edge: a low-side command must still be off after dead_cycles+1 edges and on after one more. It also breaks the command up mid-count to show the counter restarts; a design that only delays the first turn-on would switch one cycle early there. Fault rearm is exercised with the direction held high, with a rise while the flag is still active and with a proper low-to-high rise; a level-sensitive clear would let the half-bridge come back too soon. The bench further checks that a fault on one side still lets the other high-side follow its input while keeping every low gate off, that pwm chops only the low sides, and that test mode drives the high sides while ignoring the enables.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int unsigned NSIDE = 2;

    typedef logic [NSIDE-1:0] side_vec_t;

    typedef struct packed {
        side_vec_t hs;
        side_vec_t ls;
    } drive_t;
endpackage

// File: rtl/hb_fault_latch.sv
module hb_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic dir,
    input  logic trip,
    output logic latched
);
    typedef struct packed {
        logic latched;
        logic dir_prev;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.dir_prev = dir;
        if (trip) begin
            st_d.latched = 1'b1;
        end else if (st_q.latched && dir && !st_q.dir_prev) begin
            st_d.latched = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched = st_q.latched;

    assert_trip_latches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> latched);

    assert_low_dir_keeps_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !dir) |=> latched);
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime #(
    parameter int unsigned DT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            ready
);
    typedef struct packed {
        logic            prev;
        logic [DT_W-1:0] cnt;
    } dt_st_t;

    dt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cmd;
        if (cmd != st_q.prev) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < dead_cycles) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = cmd && st_q.prev && (st_q.cnt >= dead_cycles);

    assert_change_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd != st_q.prev) && (dead_cycles != '0) && $stable(dead_cycles)) |=> !ready);
endmodule

// File: rtl/hb_decode.sv
module hb_decode
    import hb_pkg::*;
(
    input  side_vec_t dir,
    input  side_vec_t en_eff,
    input  side_vec_t fault,
    input  logic      test_mode,
    input  logic      supply_ok,
    output side_vec_t hs_cmd,
    output side_vec_t ls_cmd
);
    logic any_fault;
    assign any_fault = |fault;

    for (genvar i = 0; i < NSIDE; i++) begin : g_dec
        always_comb begin
            hs_cmd[i] = 1'b0;
            ls_cmd[i] = 1'b0;
            if (supply_ok) begin
                if (test_mode) begin
                    hs_cmd[i] = dir[i] && !fault[i];
                end else begin
                    hs_cmd[i] = en_eff[i] && dir[i];
                    ls_cmd[i] = en_eff[i] && !dir[i] && !any_fault;
                end
            end
        end
    end
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hb_pkg::*;
#(
    parameter int unsigned DT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DT_W-1:0]  dead_cycles,
    input  logic [NSIDE-1:0] dir,
    input  logic [NSIDE-1:0] en_ext,
    input  logic             pwm,
    input  logic             test_mode,
    input  logic [NSIDE-1:0] ovt,
    input  logic [NSIDE-1:0] sat,
    input  logic [NSIDE-1:0] load_open,
    input  logic             uv,
    input  logic             ov,
    output logic [NSIDE-1:0] hs_on,
    output logic [NSIDE-1:0] ls_on,
    output logic [NSIDE-1:0] diag_pd
);
    side_vec_t fault_q, pd, en_eff, trip, hs_cmd, ls_cmd, ready;
    logic      supply_ok;
    drive_t    out_d, out_q;

    assign trip      = ovt | sat;
    assign pd        = fault_q | (load_open & {NSIDE{test_mode}});
    assign en_eff    = en_ext & ~pd;
    assign supply_ok = !(uv || ov);

    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        hb_fault_latch u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir     (dir[i]),
            .trip    (trip[i]),
            .latched (fault_q[i])
        );

        hb_deadtime #(.DT_W(DT_W)) u_dt (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd         (ls_cmd[i]),
            .dead_cycles (dead_cycles),
            .ready       (ready[i])
        );
    end

    hb_decode u_dec (
        .dir       (dir),
        .en_eff    (en_eff),
        .fault     (fault_q),
        .test_mode (test_mode),
        .supply_ok (supply_ok),
        .hs_cmd    (hs_cmd),
        .ls_cmd    (ls_cmd)
    );

    always_comb begin
        out_d.hs = hs_cmd;
        out_d.ls = ls_cmd & ready & {NSIDE{pwm}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hs_on   = out_q.hs;
    assign ls_on   = out_q.ls;
    assign diag_pd = pd;

    assert_no_shoot_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on & ls_on) == '0);

    assert_standby_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ext == '0 && !test_mode) |=> (hs_on == '0 && ls_on == '0));

    assert_pwm_low_gates_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm |=> (ls_on == '0));

    assert_fault_gates_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_q) |=> (ls_on == '0));

    assert_test_gates_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> (ls_on == '0));

    assert_supply_fault_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (uv || ov) |=> (hs_on == '0 && ls_on == '0));
endmodule

// File: tb/hb_ctrl_tb.sv
module hb_ctrl_tb;
    localparam int DT_W = 16;
    localparam int DEAD = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [DT_W-1:0] dead_cycles = DT_W'(DEAD);
    logic [1:0]      dir = 2'b00, en_ext = 2'b11, ovt = 2'b00, sat = 2'b00, load_open = 2'b00;
    logic            pwm = 1'b1, test_mode = 1'b0, uv = 1'b0, ov = 1'b0;
    logic [1:0]      hs_on, ls_on, diag_pd;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [1:0] hs;
        logic [1:0] ls;
        logic [1:0] pd;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    hb_ctrl #(.DT_W(DT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .dead_cycles(dead_cycles), .dir(dir), .en_ext(en_ext),
        .pwm(pwm), .test_mode(test_mode), .ovt(ovt), .sat(sat), .load_open(load_open),
        .uv(uv), .ov(ov), .hs_on(hs_on), .ls_on(ls_on), .diag_pd(diag_pd)
    );

    // Drive point: just after a falling edge.
    task automatic setin(input logic r, input logic [1:0] d, input logic [1:0] e, input logic p);
        @(negedge clk);
        #1;
        rst_n  = r;
        dir    = d;
        en_ext = e;
        pwm    = p;
    endtask

    // Wait n rising edges, then queue what the outputs must show.
    task automatic expect_after(input int n, input logic [1:0] ehs, input logic [1:0] els,
                                input logic [1:0] epd, input string tag);
        exp_t item;
        repeat (n) @(posedge clk);
        #1;
        item.hs  = ehs;
        item.ls  = els;
        item.pd  = epd;
        item.tag = tag;
        sb_q.push_back(item);
    endtask

    // Monitor: compare at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (hs_on !== it.hs || ls_on !== it.ls || diag_pd !== it.pd) begin
                    failures++;
                    $display("FAIL %s: hs=%b ls=%b pd=%b expected hs=%b ls=%b pd=%b",
                             it.tag, hs_on, ls_on, diag_pd, it.hs, it.ls, it.pd);
                end
                checks++;
                if ((hs_on & ls_on) !== 2'b00) begin
                    failures++;
                    $display("FAIL R6 (%s): hs=%b ls=%b expected no overlap", it.tag, hs_on, ls_on);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R11 reset state
        setin(1'b0, 2'b11, 2'b11, 1'b1);
        expect_after(3, 2'b00, 2'b00, 2'b00, "R11 outputs off in reset");

        // R1 modes, R5 dead time boundary
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        expect_after(1, 2'b11, 2'b00, 2'b00, "R1 brake to supply");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        expect_after(1, 2'b01, 2'b00, 2'b00, "R1 A high-side on at once");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        expect_after(3, 2'b01, 2'b00, 2'b00, "R5 B gate still off at D+1");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        expect_after(1, 2'b01, 2'b10, 2'b00, "R5 R1 B gate on at D+2");
        setin(1'b1, 2'b10, 2'b11, 1'b1);
        expect_after(1, 2'b10, 2'b00, 2'b00, "R1 other direction high-side");
        setin(1'b1, 2'b10, 2'b11, 1'b1);
        expect_after(4, 2'b10, 2'b01, 2'b00, "R1 other direction A gate");
        setin(1'b1, 2'b00, 2'b11, 1'b1);
        expect_after(1, 2'b00, 2'b01, 2'b00, "R1 brake to ground, A held");
        setin(1'b1, 2'b00, 2'b11, 1'b1);
        expect_after(4, 2'b00, 2'b11, 2'b00, "R1 brake to ground");

        // R4 pwm
        setin(1'b1, 2'b00, 2'b11, 1'b0);
        expect_after(1, 2'b00, 2'b00, 2'b00, "R4 pwm low gates off");
        setin(1'b1, 2'b00, 2'b11, 1'b1);
        expect_after(1, 2'b00, 2'b11, 2'b00, "R4 pwm high gates back");
        setin(1'b1, 2'b01, 2'b11, 1'b0);
        expect_after(1, 2'b01, 2'b00, 2'b00, "R4 high-side unaffected by pwm");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        expect_after(1, 2'b01, 2'b10, 2'b00, "R4 gate resumes");

        // R3 single half-bridge
        setin(1'b1, 2'b00, 2'b10, 1'b1);
        expect_after(1, 2'b00, 2'b10, 2'b00, "R3 only B, B gate");
        setin(1'b1, 2'b11, 2'b10, 1'b1);
        expect_after(1, 2'b10, 2'b00, 2'b00, "R3 only B, B high-side");
        setin(1'b1, 2'b11, 2'b01, 1'b1);
        expect_after(1, 2'b01, 2'b00, 2'b00, "R3 only A, A high-side");

        // R2 standby
        setin(1'b1, 2'b01, 2'b00, 1'b1);
        expect_after(1, 2'b00, 2'b00, 2'b00, "R2 standby dir 01");
        setin(1'b1, 2'b10, 2'b00, 1'b1);
        expect_after(1, 2'b00, 2'b00, 2'b00, "R2 standby dir 10");

        // R5 restart on command change
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        expect_after(1, 2'b11, 2'b00, 2'b00, "R1 brake to supply again");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        expect_after(2, 2'b01, 2'b00, 2'b00, "R5 partial count");
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        expect_after(1, 2'b11, 2'b00, 2'b00, "R5 command withdrawn");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        expect_after(4, 2'b01, 2'b00, 2'b00, "R5 restarted count not done");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        expect_after(1, 2'b01, 2'b10, 2'b00, "R5 restarted count done");

        // R7 fault latch on A
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        ovt = 2'b01;
        expect_after(1, 2'b01, 2'b10, 2'b01, "R7 diag asserted at latch edge");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        ovt = 2'b00;
        expect_after(1, 2'b00, 2'b00, 2'b01, "R7 R8 outputs off, held dir keeps latch");
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        expect_after(1, 2'b10, 2'b00, 2'b01, "R7 B high-side follows");
        setin(1'b1, 2'b00, 2'b11, 1'b1);
        expect_after(1, 2'b00, 2'b00, 2'b01, "R7 low gates held off");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        expect_after(1, 2'b00, 2'b00, 2'b00, "R8 rise clears latch");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        expect_after(1, 2'b01, 2'b00, 2'b00, "R8 A high-side back");

        // R7 saturation on B, R8 rise with flag active
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        sat = 2'b10;
        expect_after(2, 2'b01, 2'b00, 2'b10, "R7 sat on B, A still on");
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        expect_after(1, 2'b01, 2'b00, 2'b10, "R8 rise with flag high stays latched");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        sat = 2'b00;
        expect_after(1, 2'b01, 2'b00, 2'b10, "R8 still latched");
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        expect_after(2, 2'b11, 2'b00, 2'b00, "R8 clean rise clears B");

        // R11 reset clears a latched fault
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        ovt = 2'b10;
        repeat (1) @(posedge clk);
        setin(1'b0, 2'b11, 2'b11, 1'b1);
        ovt = 2'b00;
        expect_after(2, 2'b00, 2'b00, 2'b00, "R11 reset clears latch");
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        expect_after(1, 2'b11, 2'b00, 2'b00, "R11 normal after reset");

        // R9 test mode
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        test_mode = 1'b1;
        expect_after(1, 2'b01, 2'b00, 2'b00, "R9 high-side follows dir");
        setin(1'b1, 2'b01, 2'b11, 1'b1);
        load_open = 2'b10;
        expect_after(1, 2'b01, 2'b00, 2'b10, "R9 open load pulls diag");
        setin(1'b1, 2'b11, 2'b00, 1'b1);
        expect_after(1, 2'b11, 2'b00, 2'b10, "R9 enables ignored");
        setin(1'b1, 2'b00, 2'b11, 1'b1);
        expect_after(1, 2'b00, 2'b00, 2'b10, "R9 no low gates");
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        test_mode = 1'b0;
        load_open = 2'b00;
        expect_after(1, 2'b11, 2'b00, 2'b00, "R9 exit test mode");

        // R10 supply faults
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        uv = 1'b1;
        expect_after(1, 2'b00, 2'b00, 2'b00, "R10 undervoltage off");
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        uv = 1'b0;
        expect_after(1, 2'b11, 2'b00, 2'b00, "R10 undervoltage recovered");
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        ov = 1'b1;
        expect_after(1, 2'b00, 2'b00, 2'b00, "R10 overvoltage off");
        setin(1'b1, 2'b11, 2'b11, 1'b1);
        ov = 1'b0;
        expect_after(1, 2'b11, 2'b00, 2'b00, "R10 overvoltage recovered");

        @(negedge clk);
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule